// File: doc/BRIEF.md
# Dual-Rate Conversion Scheduler

This block produces the completion timing for a measurement front end that carries two converters: a quick, coarse one and a slow, fine one. It counts cycles of the reference clock (4 MHz in normal use). A two-bit rate code sets how long one quick conversion takes. The slow conversion always lasts exactly ten quick conversions. The block gives a one-cycle strobe for each finished quick conversion and another for each finished slow conversion. It does not model the converters' analog phases or arithmetic. A conversion is only a timed event.

For an external host, the block drives a level-type "result waiting" output. It rises whenever a quick conversion finishes and stays high until the serial slave reports that the host's read header was accepted. If a new result arrives while the previous one is still waiting, a sticky overrun flag is raised. A low chip-select puts the scheduler to sleep and freezes conversion timing. When chip-select returns high, timing starts again from a clean period.

Top module: `convsched_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, fast_done, slow_done, data_ready and overrun are all 0.
- R2: With chip_sel high and rate_sel constant, fast_done is a one-cycle pulse repeating every P cycles. The value of P depends on rate_sel: 2'b00 gives P0, 2'b01 gives P1, 2'b10 gives P2 and 2'b11 gives P3. The default values are 200000, 120000, 100000 and 80000 cycles, which are 50, 30, 25 and 20 ms at 4 MHz. The slow period is ten times P. The first pulse after reset is released comes P cycles later.
- R3: slow_done pulses only together with fast_done, on every tenth fast_done counted from the last restart.
- R4: When rate_sel changes while awake, the quick-period count and the sub-cycle index both restart from zero. The first fast_done under the new code comes P(new)+1 cycles after the new code is first presented before a clock edge.
- R5: While chip_sel is low, no fast_done or slow_done is produced and both counts are held at zero. After chip_sel rises, the first fast_done comes a full P cycles later and the tenth one carries slow_done.
- R6: data_ready goes high in the same cycle as every fast_done and stays high with no further activity.
- R7: When rd_ack is high at a clock edge, data_ready and overrun are 0 from the next cycle, unless a conversion completes at that same edge. In that case data_ready stays 1.
- R8: A completion that arrives while data_ready is 1 and rd_ack is low sets overrun, visible in the same cycle as the fast_done that caused it. Overrun stays set until rd_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel | input | 1 | High = awake, low = sleep |
| rate_sel | input | 2 | Conversion rate code |
| rd_ack | input | 1 | Host read header accepted; clears data_ready and overrun |
| fast_done | output | 1 | One-cycle quick conversion completion strobe |
| slow_done | output | 1 | One-cycle slow conversion completion strobe |
| data_ready | output | 1 | Sticky level: a result is waiting for the host |
| overrun | output | 1 | Sticky: a result arrived while the previous one was unread |

## Verification
A wrong period count or a missed restart first shows up as a fast_done pulse in the wrong cycle. It is visible within one quick period of the fault, which is a few cycles when the bench uses short periods. A wrong sub-cycle index moves slow_done to some other fast_done. That is seen within ten quick periods. Mistakes in the ready or overrun flags appear at the first completion or read acknowledge that meets them, because the bench compares every output against its own reference model in every cycle and also times the gaps between strobes directly.

// File: rtl/convsched_pkg.sv
package convsched_pkg;

    typedef enum logic [1:0] {
        RATE_500 = 2'b00,
        RATE_300 = 2'b01,
        RATE_250 = 2'b10,
        RATE_200 = 2'b11
    } rate_code_t;

    typedef struct packed {
        logic fast;
        logic slow;
    } conv_evt_t;

    localparam int SUB_PER_SLOW = 10;

    function automatic int pick_period(rate_code_t c, int p0, int p1, int p2, int p3);
        case (c)
            RATE_500: return p0;
            RATE_300: return p1;
            RATE_250: return p2;
            default:  return p3;
        endcase
    endfunction

    function automatic int max_of4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/convsched_fast_timer.sv
module convsched_fast_timer
    import convsched_pkg::*;
#(
    parameter int P0 = 200000,
    parameter int P1 = 120000,
    parameter int P2 = 100000,
    parameter int P3 = 80000,
    parameter int CNT_W = 18
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       restart,
    input  rate_code_t code,
    output logic       tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    always_comb begin
        last = CNT_W'(pick_period(code, P0, P1, P2, P3) - 1);
        tick = run && !restart && (cnt == last);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || restart)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/convsched_sub_index.sv
module convsched_sub_index #(
    parameter int RATIO = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    input  logic tick,
    output logic slow_tick
);
    localparam int IDX_W = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(RATIO - 1);

    logic [IDX_W-1:0] idx;

    always_comb slow_tick = tick && (idx == IDX_LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || restart)
            idx <= '0;
        else if (tick)
            idx <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
    end
endmodule

// File: rtl/convsched_ready_flag.sv
module convsched_ready_flag (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic clear,
    output logic ready,
    output logic overrun
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ready   <= 1'b0;
            overrun <= 1'b0;
        end else begin
            ready <= evt || (ready && !clear);
            if (evt && ready && !clear)
                overrun <= 1'b1;
            else if (clear)
                overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/convsched_top.sv
module convsched_top
    import convsched_pkg::*;
#(
    parameter int P0 = 200000,
    parameter int P1 = 120000,
    parameter int P2 = 100000,
    parameter int P3 = 80000,
    parameter int RATIO = SUB_PER_SLOW
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       chip_sel,
    input  logic [1:0] rate_sel,
    input  logic       rd_ack,
    output logic       fast_done,
    output logic       slow_done,
    output logic       data_ready,
    output logic       overrun
);
    localparam int PMAX  = max_of4(P0, P1, P2, P3);
    localparam int CNT_W = $clog2(PMAX + 1);

    rate_code_t rate_q;
    rate_code_t rate_in;
    logic       restart;
    logic       tick;
    logic       slow_tick;
    conv_evt_t  evt_q;

    always_comb begin
        rate_in = rate_code_t'(rate_sel);
        restart = chip_sel && (rate_in != rate_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= RATE_500;
            evt_q  <= '0;
        end else begin
            rate_q     <= rate_in;
            evt_q.fast <= tick;
            evt_q.slow <= slow_tick;
        end
    end

    convsched_fast_timer #(
        .P0(P0), .P1(P1), .P2(P2), .P3(P3), .CNT_W(CNT_W)
    ) u_fast (
        .clk(clk), .rst(rst), .run(chip_sel), .restart(restart),
        .code(rate_q), .tick(tick)
    );

    convsched_sub_index #(.RATIO(RATIO)) u_sub (
        .clk(clk), .rst(rst), .run(chip_sel), .restart(restart),
        .tick(tick), .slow_tick(slow_tick)
    );

    convsched_ready_flag u_rdy (
        .clk(clk), .rst(rst), .evt(tick), .clear(rd_ack),
        .ready(data_ready), .overrun(overrun)
    );

    always_comb begin
        fast_done = evt_q.fast;
        slow_done = evt_q.slow;
    end
endmodule

// File: rtl/convsched_checker.sv
module convsched_checker (
    input logic       clk,
    input logic       rst,
    input logic       chip_sel,
    input logic [1:0] rate_sel,
    input logic       rd_ack,
    input logic       fast_done,
    input logic       slow_done,
    input logic       data_ready,
    input logic       overrun
);
    // R2: the quick strobe lasts one cycle
    assert_fast_single_R2: assert property (@(posedge clk) disable iff (rst)
        fast_done |=> !fast_done);

    // R3: slow completion only together with a quick one
    assert_slow_with_fast_R3: assert property (@(posedge clk) disable iff (rst)
        slow_done |-> fast_done);

    // R4: a sampled code change suppresses the completion at that edge
    assert_code_change_restart_R4: assert property (@(posedge clk) disable iff (rst)
        (chip_sel && rate_sel != $past(rate_sel)) |=> !fast_done);

    // R5: asleep means no strobes
    assert_sleep_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !chip_sel |=> (!fast_done && !slow_done));

    // R6: ready accompanies every completion
    assert_ready_on_done_R6: assert property (@(posedge clk) disable iff (rst)
        fast_done |-> data_ready);

    // R7: ready only falls after an acknowledge
    assert_ready_fall_ack_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(data_ready) |-> $past(rd_ack));

    // R8: overrun only rises with a completion
    assert_overrun_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> fast_done);
endmodule

bind convsched_top convsched_checker u_chk (
    .clk(clk), .rst(rst), .chip_sel(chip_sel), .rate_sel(rate_sel),
    .rd_ack(rd_ack), .fast_done(fast_done), .slow_done(slow_done),
    .data_ready(data_ready), .overrun(overrun)
);

// File: tb/tb_convsched_top.sv
module tb_convsched_top;
    localparam int TP0 = 20;
    localparam int TP1 = 12;
    localparam int TP2 = 10;
    localparam int TP3 = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       chip_sel;
    logic [1:0] rate_sel;
    logic       rd_ack;
    logic       fast_done, slow_done, data_ready, overrun;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done_f = 0;

    // reference model state
    int m_cnt, m_idx, m_rate;
    bit m_fd, m_sd, m_rdy, m_ovr;

    always #2.5 clk = ~clk;

    convsched_top #(.P0(TP0), .P1(TP1), .P2(TP2), .P3(TP3)) dut (
        .clk(clk), .rst(rst), .chip_sel(chip_sel), .rate_sel(rate_sel),
        .rd_ack(rd_ack), .fast_done(fast_done), .slow_done(slow_done),
        .data_ready(data_ready), .overrun(overrun)
    );

    function automatic int per(int code);
        case (code)
            0: return TP0;
            1: return TP1;
            2: return TP2;
            default: return TP3;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_idx = 0; m_rate = 0;
        m_fd = 0; m_sd = 0; m_rdy = 0; m_ovr = 0;
    endtask

    // advance the model with the inputs now driven, then compare after the edge
    task automatic step();
        bit tk;
        bit rc;
        rc = !chip_sel || (int'(rate_sel) != m_rate);
        tk = chip_sel && (int'(rate_sel) == m_rate) && (m_cnt == per(m_rate) - 1);
        m_sd = tk && (m_idx == 9);
        m_fd = tk;
        if (tk && m_rdy && !rd_ack) m_ovr = 1;
        else if (rd_ack) m_ovr = 0;
        m_rdy = tk || (m_rdy && !rd_ack);
        if (rc) begin m_cnt = 0; m_idx = 0; end
        else if (tk) begin m_cnt = 0; m_idx = (m_idx == 9) ? 0 : m_idx + 1; end
        else m_cnt = m_cnt + 1;
        m_rate = int'(rate_sel);
        @(negedge clk);
        check("R2 fast_done", int'(fast_done), int'(m_fd));
        check("R3 slow_done", int'(slow_done), int'(m_sd));
        check("R6 data_ready", int'(data_ready), int'(m_rdy));
        check("R8 overrun", int'(overrun), int'(m_ovr));
    endtask

    // count cycles until fast_done is seen (inputs held)
    task automatic wait_fast(output int n, output bit sl);
        n = 0;
        sl = 0;
        do begin
            step();
            n++;
        end while (!fast_done && n < 400);
        sl = slow_done;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done_f) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        int n;
        bit sl;
        void'($urandom(32'd4711));
        rst = 1; chip_sel = 1; rate_sel = 2'b00; rd_ack = 0;
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 fast_done", int'(fast_done), 0);
        check("R1 slow_done", int'(slow_done), 0);
        check("R1 data_ready", int'(data_ready), 0);
        check("R1 overrun", int'(overrun), 0);
        rst = 0;
        step();
        check("R1 data_ready after release", int'(data_ready), 0);

        // R2: first pulse after reset (one step already taken), then steady periods per code
        wait_fast(n, sl);
        check("R2 first period code 00", n + 1, TP0);
        for (int c = 0; c < 4; c++) begin
            rate_sel = 2'(c);
            wait_fast(n, sl);
            if (c != 0) check("R4 first pulse after code change", n, per(c) + 1);
            wait_fast(n, sl);
            check("R2 steady period", n, per(c));
            rd_ack = 1; step(); rd_ack = 0;
        end

        // R3: count quick completions between slow completions at code 11
        do wait_fast(n, sl); while (!sl);
        begin
            int k = 0;
            do begin wait_fast(n, sl); k++; end while (!sl);
            check("R3 quick per slow", k, 10);
        end

        // R8 and R7: two unread completions, then acknowledge
        rd_ack = 1; step(); rd_ack = 0;
        wait_fast(n, sl);
        check("R8 no overrun on first", int'(overrun), 0);
        wait_fast(n, sl);
        check("R8 overrun on second", int'(overrun), 1);
        rd_ack = 1; step(); rd_ack = 0;
        check("R7 ready cleared", int'(data_ready), 0);
        check("R7 overrun cleared", int'(overrun), 0);

        // R5: sleep, then wake with full period and fresh sub index
        chip_sel = 0;
        for (int i = 0; i < 60; i++) begin
            step();
            check("R5 no strobe asleep", int'(fast_done | slow_done), 0);
        end
        chip_sel = 1;
        wait_fast(n, sl);
        check("R5 first period after wake", n, per(3));
        begin
            int k = 1;
            while (!sl) begin wait_fast(n, sl); k++; end
            check("R5 slow on tenth after wake", k, 10);
        end

        // R7: acknowledge at the completion edge keeps ready high
        rd_ack = 0;
        while (1) begin
            step();
            if (m_cnt == per(m_rate) - 1) break;
        end
        rd_ack = 1; step(); rd_ack = 0;
        check("R7 ack at completion keeps ready", int'(data_ready), 1);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            rd_ack = ($urandom % 25) == 0;
            if (($urandom % 300) == 0) rate_sel = 2'($urandom);
            if (chip_sel && ($urandom % 500) == 0) chip_sel = 0;
            else if (!chip_sel && ($urandom % 30) == 0) chip_sel = 1;
            step();
        end

        done_f = 1;
        summary();
    end
endmodule